// File: doc/BRIEF.md
# Domain and Permission Access Checker

This block rules on whether a memory access that has already been translated may go ahead. It receives the translation outcome (the mapping size, one of sixteen domain numbers, either one permission code or four per-quarter permission codes, and the virtual address), together with the direction of the access, the privilege level of the requester and a 32-bit domain control word that software owns. One clock after a request strobe it presents a registered verdict: allow or abort, a fault class, and a single-cycle fault pulse for aborted requests.

Each domain carries a two-bit mode. A client domain sends the access through the permission check. A manager domain lets it through whatever the permission bits say. A no-access domain, or the reserved code, aborts it whatever the permission bits say. For large and small pages the permission code is taken from the quarter of the page that the address falls in. Sections and tiny pages carry a single code.

Top module: `access_guard`

## Requirements
- R1: While reset is high, on the following clock edge rsp_valid, rsp_allow, rsp_abort and fault_pulse are 0 and rsp_fault is 00.
- R2: A request sampled with req_valid high produces rsp_valid high on the very next clock edge. rsp_valid is low after any edge where req_valid was low.
- R3: The mode of domain d is bits [2d+1:2d] of dacr, where d is req_domain (0 to 15).
- R4: A domain in mode 11 (manager) allows the access with fault code 00, whatever the permission codes, direction or privilege.
- R5: A domain in mode 00 (no access) or 10 (reserved) aborts the access with fault code 01 (domain fault), whatever the permission codes. A domain fault takes priority over any permission failure.
- R6: A domain in mode 01 (client) applies the selected 2-bit permission code. 00 denies everything. 01 grants privileged reads and writes only. 10 grants privileged reads and writes and user reads. 11 grants every access. req_write is 1 for a write, and req_priv is 1 for privileged mode.
- R7: A client access denied by its permission code aborts with fault code 10 (permission fault).
- R8: For a large page (req_size 01), quarter k = req_vaddr[15:14] selects code req_perm[2k+1:2k].
- R9: For a small page (req_size 10), quarter k = req_vaddr[11:10] selects code req_perm[2k+1:2k].
- R10: For a section (req_size 00) or a tiny page (req_size 11), only req_perm[1:0] is used. The upper three fields and the address bits have no effect.
- R11: When rsp_valid is high, exactly one of rsp_allow and rsp_abort is high. fault_pulse is high for exactly the one cycle in which an aborted verdict is presented, and the fault code is 00 on an allow.
- R12: After an edge where req_valid is low, rsp_allow, rsp_abort and rsp_fault keep their previous values and fault_pulse is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe |
| req_size | input | 2 | Mapping size: 00 section, 01 large page, 10 small page, 11 tiny page |
| req_domain | input | 4 | Domain number of the mapping |
| req_perm | input | 8 | Four 2-bit permission codes, quarter k at [2k+1:2k] |
| req_vaddr | input | 32 | Virtual address of the access |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_priv | input | 1 | 1 for privileged mode, 0 for user mode |
| dacr | input | 32 | Domain control word, 2 bits per domain |
| rsp_valid | output | 1 | Verdict presented this cycle |
| rsp_allow | output | 1 | Access may proceed |
| rsp_abort | output | 1 | Access is aborted |
| rsp_fault | output | 2 | 00 none, 01 domain fault, 10 permission fault |
| fault_pulse | output | 1 | One-cycle pulse for an aborted request |

## Verification
The domain abort and the permission failure can both apply to the same request, namely when a no-access or reserved domain points at a permission code that would also deny the access. The bench provokes this with directed requests that pair mode 00 or 10 with code 00, or with a user write against code 10. It also draws random domain words and permission sets in which such overlaps are common. A verdict is judged correct only when it reports fault code 01, never 10. The reverse overlap, a manager domain over a denying code, must give an allow with fault code 00.

// File: rtl/guard_pkg.sv
package guard_pkg;

    localparam int NUM_DOMAINS   = 16;
    localparam int DOM_W         = 2;
    localparam int PERM_W        = 2;
    localparam int SUBPAGES      = 4;
    localparam int ADDR_W        = 32;
    localparam int LARGE_SUB_LSB = 14;
    localparam int SMALL_SUB_LSB = 10;

    localparam int DOM_IDX_W = $clog2(NUM_DOMAINS);
    localparam int DACR_W    = NUM_DOMAINS * DOM_W;
    localparam int PERMSET_W = SUBPAGES * PERM_W;
    localparam int SUB_IDX_W = $clog2(SUBPAGES);

    typedef enum logic [1:0] {
        MAP_SECTION = 2'b00,
        MAP_LARGE   = 2'b01,
        MAP_SMALL   = 2'b10,
        MAP_TINY    = 2'b11
    } map_size_e;

    typedef enum logic [DOM_W-1:0] {
        DOM_NONE    = 2'b00,
        DOM_CLIENT  = 2'b01,
        DOM_RSVD    = 2'b10,
        DOM_MANAGER = 2'b11
    } dom_mode_e;

    typedef enum logic [PERM_W-1:0] {
        AP_NONE    = 2'b00,
        AP_PRIV    = 2'b01,
        AP_USER_RO = 2'b10,
        AP_FULL    = 2'b11
    } perm_e;

    typedef enum logic [1:0] {
        FLT_NONE   = 2'b00,
        FLT_DOMAIN = 2'b01,
        FLT_PERM   = 2'b10
    } fault_e;

    typedef struct packed {
        logic   allow;
        logic   abort;
        fault_e fault;
    } verdict_t;

    // Decide whether one permission code grants the given access.
    function automatic logic perm_grants(perm_e ap, logic is_write, logic is_priv);
        logic ok;
        case (ap)
            AP_NONE:    ok = 1'b0;
            AP_PRIV:    ok = is_priv;
            AP_USER_RO: ok = is_priv | ~is_write;
            AP_FULL:    ok = 1'b1;
            default:    ok = 1'b0;
        endcase
        return ok;
    endfunction

    // Combine the domain mode and the permission result into a verdict.
    function automatic verdict_t judge(dom_mode_e mode, logic granted);
        verdict_t v;
        case (mode)
            DOM_MANAGER: v = '{allow: 1'b1, abort: 1'b0, fault: FLT_NONE};
            DOM_CLIENT: begin
                if (granted) v = '{allow: 1'b1, abort: 1'b0, fault: FLT_NONE};
                else         v = '{allow: 1'b0, abort: 1'b1, fault: FLT_PERM};
            end
            default:     v = '{allow: 1'b0, abort: 1'b1, fault: FLT_DOMAIN};
        endcase
        return v;
    endfunction

endpackage

// File: rtl/guard_domain_sel.sv
module guard_domain_sel
    import guard_pkg::*;
(
    input  logic [DACR_W-1:0]    dacr,
    input  logic [DOM_IDX_W-1:0] dom,
    output dom_mode_e            mode
);

    dom_mode_e modes [NUM_DOMAINS];

    for (genvar g = 0; g < NUM_DOMAINS; g++) begin : g_split
        assign modes[g] = dom_mode_e'(dacr[g*DOM_W +: DOM_W]);
    end

    assign mode = modes[dom];

endmodule

// File: rtl/guard_subpage_mux.sv
module guard_subpage_mux
    import guard_pkg::*;
(
    input  map_size_e             size,
    input  logic [ADDR_W-1:0]     vaddr,
    input  logic [PERMSET_W-1:0]  perm_set,
    output perm_e                 ap
);

    localparam logic [ADDR_W-1:0] QMASK     = ADDR_W'((1 << SUB_IDX_W) - 1);
    localparam logic [ADDR_W-1:0] USED_MASK = (QMASK << LARGE_SUB_LSB) |
                                              (QMASK << SMALL_SUB_LSB);

    perm_e                fields [SUBPAGES];
    logic [SUB_IDX_W-1:0] idx;
    logic                 unused_vaddr;

    for (genvar g = 0; g < SUBPAGES; g++) begin : g_field
        assign fields[g] = perm_e'(perm_set[g*PERM_W +: PERM_W]);
    end

    always_comb begin
        case (size)
            MAP_LARGE: idx = vaddr[LARGE_SUB_LSB +: SUB_IDX_W];
            MAP_SMALL: idx = vaddr[SMALL_SUB_LSB +: SUB_IDX_W];
            default:   idx = '0;
        endcase
    end

    assign ap           = fields[idx];
    assign unused_vaddr = ^(vaddr & ~USED_MASK);

endmodule

// File: rtl/guard_perm_eval.sv
module guard_perm_eval
    import guard_pkg::*;
(
    input  perm_e ap,
    input  logic  is_write,
    input  logic  is_priv,
    output logic  granted
);

    assign granted = perm_grants(ap, is_write, is_priv);

endmodule

// File: rtl/access_guard.sv
module access_guard
    import guard_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 req_valid,
    input  logic [1:0]           req_size,
    input  logic [DOM_IDX_W-1:0] req_domain,
    input  logic [PERMSET_W-1:0] req_perm,
    input  logic [ADDR_W-1:0]    req_vaddr,
    input  logic                 req_write,
    input  logic                 req_priv,
    input  logic [DACR_W-1:0]    dacr,
    output logic                 rsp_valid,
    output logic                 rsp_allow,
    output logic                 rsp_abort,
    output logic [1:0]           rsp_fault,
    output logic                 fault_pulse
);

    dom_mode_e mode;
    perm_e     ap;
    logic      granted;
    verdict_t  next_v;
    verdict_t  held_v;
    logic      valid_q;
    logic      pulse_q;

    guard_domain_sel i_dom (
        .dacr (dacr),
        .dom  (req_domain),
        .mode (mode)
    );

    guard_subpage_mux i_sub (
        .size     (map_size_e'(req_size)),
        .vaddr    (req_vaddr),
        .perm_set (req_perm),
        .ap       (ap)
    );

    guard_perm_eval i_perm (
        .ap       (ap),
        .is_write (req_write),
        .is_priv  (req_priv),
        .granted  (granted)
    );

    assign next_v = judge(mode, granted);

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            pulse_q <= 1'b0;
            held_v  <= '{allow: 1'b0, abort: 1'b0, fault: FLT_NONE};
        end else begin
            valid_q <= req_valid;
            pulse_q <= req_valid & next_v.abort;
            if (req_valid) held_v <= next_v;
        end
    end

    assign rsp_valid   = valid_q;
    assign rsp_allow   = held_v.allow;
    assign rsp_abort   = held_v.abort;
    assign rsp_fault   = held_v.fault;
    assign fault_pulse = pulse_q;

endmodule

// File: rtl/guard_checks.sv
module guard_checks (
    input logic        clk,
    input logic        rst,
    input logic        req_valid,
    input logic [1:0]  req_size,
    input logic [3:0]  req_domain,
    input logic [7:0]  req_perm,
    input logic [31:0] req_vaddr,
    input logic        req_write,
    input logic        req_priv,
    input logic [31:0] dacr,
    input logic        rsp_valid,
    input logic        rsp_allow,
    input logic        rsp_abort,
    input logic [1:0]  rsp_fault,
    input logic        fault_pulse
);

    logic [1:0] cur_mode;
    assign cur_mode = 2'(dacr >> {req_domain, 1'b0});

    p_reset_state_r1: assert property (@(posedge clk)
        rst |=> (!rsp_valid && !rsp_allow && !rsp_abort && rsp_fault == 2'b00 && !fault_pulse));

    p_valid_next_r2: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);

    p_idle_quiet_r2: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_valid);

    p_manager_allow_r4: assert property (@(posedge clk) disable iff (rst)
        (req_valid && cur_mode == 2'b11) |=> (rsp_allow && rsp_fault == 2'b00));

    p_domain_fault_r5: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !cur_mode[0]) |=> (rsp_abort && rsp_fault == 2'b01));

    p_one_verdict_r11: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> $countones({rsp_allow, rsp_abort}) == 1);

    p_pulse_abort_r11: assert property (@(posedge clk) disable iff (rst)
        fault_pulse |-> (rsp_valid && rsp_abort && rsp_fault != 2'b00));

    p_allow_clean_r11: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_allow) |-> (rsp_fault == 2'b00 && !fault_pulse));

    p_hold_r12: assert property (@(posedge clk) disable iff (rst)
        (!req_valid && !$past(rst)) |=> ($stable(rsp_allow) && $stable(rsp_abort) &&
                                         $stable(rsp_fault) && !fault_pulse));

endmodule

bind access_guard guard_checks i_checks (.*);

// File: tb/test_access_guard.sv
module test_access_guard;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [1:0]  req_size = '0;
    logic [3:0]  req_domain = '0;
    logic [7:0]  req_perm = '0;
    logic [31:0] req_vaddr = '0;
    logic        req_write = 1'b0;
    logic        req_priv = 1'b0;
    logic [31:0] dacr = '0;
    logic        rsp_valid;
    logic        rsp_allow;
    logic        rsp_abort;
    logic [1:0]  rsp_fault;
    logic        fault_pulse;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    access_guard i_access_guard (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_size(req_size),
        .req_domain(req_domain), .req_perm(req_perm), .req_vaddr(req_vaddr),
        .req_write(req_write), .req_priv(req_priv), .dacr(dacr),
        .rsp_valid(rsp_valid), .rsp_allow(rsp_allow), .rsp_abort(rsp_abort),
        .rsp_fault(rsp_fault), .fault_pulse(fault_pulse)
    );

    // Expected {allow, abort, fault} from the requirements.
    function automatic logic [3:0] model(logic [1:0] sz, logic [3:0] dom, logic [7:0] perms,
                                         logic [31:0] va, logic wr, logic pv, logic [31:0] dw);
        logic [1:0] m;
        logic [1:0] q;
        logic [1:0] code;
        logic       ok;
        m = dw[dom*2 +: 2];                               // R3
        if (m == 2'b11) return 4'b1000;                   // R4
        if (m == 2'b00 || m == 2'b10) return 4'b0101;     // R5
        if (sz == 2'b01)      q = va[15:14];              // R8
        else if (sz == 2'b10) q = va[11:10];              // R9
        else                  q = 2'd0;                   // R10
        code = perms[q*2 +: 2];
        ok = (code == 2'b11) || (code == 2'b10 && (pv || !wr)) || (code == 2'b01 && pv); // R6
        return ok ? 4'b1000 : 4'b0110;                    // R7
    endfunction

    task automatic check(string req, logic [5:0] got, logic [5:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s got=%b exp=%b (valid,allow,abort,fault,pulse)", req, got, exp);
        end
    endtask

    // One request, verdict sampled at the next falling edge.
    task automatic issue(string req, logic [1:0] sz, logic [3:0] dom, logic [7:0] perms,
                         logic [31:0] va, logic wr, logic pv, logic [31:0] dw);
        logic [3:0] e;
        @(negedge clk);
        req_size = sz; req_domain = dom; req_perm = perms; req_vaddr = va;
        req_write = wr; req_priv = pv; dacr = dw; req_valid = 1'b1;
        e = model(sz, dom, perms, va, wr, pv, dw);
        @(negedge clk);
        req_valid = 1'b0;
        check(req, {rsp_valid, rsp_allow, rsp_abort, rsp_fault, fault_pulse},
              {1'b1, e, e[2]});
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : stim
        logic [5:0] last;
        void'($urandom(32'h00C0FFEE));
        repeat (3) @(negedge clk);
        check("R1 reset", {rsp_valid, rsp_allow, rsp_abort, rsp_fault, fault_pulse}, 6'b0);
        rst = 1'b0;
        @(negedge clk);
        check("R2 idle after reset", {rsp_valid, fault_pulse}, 6'b0);

        // R4 manager overrides a denying code
        issue("R4 manager", 2'b00, 4'd5, 8'h00, 32'h0, 1'b1, 1'b0, 32'h0000_0C00);
        // R5 no-access and reserved with a denying code: domain fault wins
        issue("R5 no access", 2'b00, 4'd2, 8'h00, 32'h0, 1'b1, 1'b0, 32'hFFFF_FFCF);
        issue("R5 reserved", 2'b01, 4'd15, 8'hAA, 32'h0, 1'b1, 1'b0, 32'h8000_0000);
        // R6/R7 client codes
        issue("R6 priv code user read", 2'b11, 4'd0, 8'h01, 32'h0, 1'b0, 1'b0, 32'h1);
        issue("R6 priv code priv write", 2'b11, 4'd0, 8'h01, 32'h0, 1'b1, 1'b1, 32'h1);
        issue("R6 user-ro user read", 2'b00, 4'd0, 8'h02, 32'h0, 1'b0, 1'b0, 32'h1);
        issue("R7 user-ro user write", 2'b00, 4'd0, 8'h02, 32'h0, 1'b1, 1'b0, 32'h1);
        issue("R7 none priv read", 2'b00, 4'd0, 8'hFC, 32'h0, 1'b0, 1'b1, 32'h1);
        // R8 large page: quarter 2 is full, others none
        issue("R8 large q2", 2'b01, 4'd1, 8'h30, 32'h0000_8000, 1'b1, 1'b0, 32'h4);
        issue("R8 large q1", 2'b01, 4'd1, 8'h30, 32'h0000_4C00, 1'b1, 1'b0, 32'h4);
        // R9 small page: quarter 3 is full
        issue("R9 small q3", 2'b10, 4'd1, 8'hC0, 32'h0000_0C00, 1'b1, 1'b0, 32'h4);
        issue("R9 small q0", 2'b10, 4'd1, 8'hC0, 32'h0000_C000, 1'b1, 1'b0, 32'h4);
        // R10 section/tiny ignore upper fields and address
        issue("R10 section", 2'b00, 4'd1, 8'hFC, 32'h0000_CC00, 1'b0, 1'b1, 32'h4);
        issue("R10 tiny", 2'b11, 4'd1, 8'h03, 32'hFFFF_FFFF, 1'b1, 1'b0, 32'h4);

        // R12 hold: outputs stay after an idle edge, pulse drops
        last = {1'b0, rsp_allow, rsp_abort, rsp_fault, 1'b0};
        @(negedge clk);
        check("R12 hold", {rsp_valid, rsp_allow, rsp_abort, rsp_fault, fault_pulse}, last);
        issue("R11 abort then", 2'b00, 4'd3, 8'h00, 32'h0, 1'b0, 1'b1, 32'h0);
        @(negedge clk);
        check("R11 pulse one cycle", {rsp_valid, rsp_allow, rsp_abort, rsp_fault, fault_pulse},
              6'b001010);

        for (int i = 0; i < 3000; i++) begin
            issue("R3 random", 2'($urandom), 4'($urandom), 8'($urandom), $urandom,
                  1'($urandom), 1'($urandom), $urandom);
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule